// File: doc/BRIEF.md
# Cartridge/DRAM Block-Copy DMA Engine

This block copies a run of bytes between a cartridge-side memory and main DRAM. Software sets it up through a small 32-bit register port. It first writes the two start addresses. It then writes one of two length registers. The length register chosen picks the direction of the copy, and the write itself starts the transfer.

When the transfer starts, the engine takes aligned copies of both addresses. If the DRAM start is not on an 8-byte boundary, it shortens the byte count. It then moves one byte per cycle through a request/ready handshake on each memory port. During the copy, software can poll the busy bits in the status register. When the last byte lands, both address registers advance past the copied block and a level interrupt is raised. The interrupt stays high until software clears it through the status register. Software can also abort a copy through the status register.

Top module: `cart_dma_engine`

## Requirements
- R1: Register offsets are 0x00 (DRAM address), 0x04 (cartridge address), 0x08 (DRAM-to-cartridge length), 0x0C (cartridge-to-DRAM length) and 0x10 (status). While idle, the two address registers read back the full 32-bit value written.
- R2: An idle write to 0x08 starts a copy from DRAM to the cartridge, with the DRAM port reading and the cartridge port writing. An idle write to 0x0C starts the opposite copy.
- R3: The requested byte count is the low LEN_W bits of the written length value plus one (LEN_W is 24 by default). Higher bits are ignored.
- R4: At the start of a copy, the cartridge base is the cartridge register with bit 0 cleared. The DRAM base is the DRAM register cut to DRAM_AW bits (23 by default) with bit 0 cleared. Byte i of the copy uses base+i on each port.
- R5: The byte count is reduced by the DRAM base's low three bits. If that reduction is not smaller than the requested count, zero bytes move and the copy completes one cycle after it started.
- R6: The adjusted byte count of each direction is held in, and read back from, that direction's own length offset.
- R7: Status bit 0 (DMA busy) and bit 1 (IO busy) both read 1 from the cycle after the starting write until completion. Bit 2 (error) is always 0. Bit 3 is the pending interrupt. All other bits read 0.
- R8: On completion, each address register becomes its base plus the adjusted count. The interrupt output rises in the same cycle and stays high until it is cleared.
- R9: A status write with bit 1 set clears the pending interrupt and lowers the interrupt output, unless a completion happens in that same cycle.
- R10: Writes to the address or length registers while busy are ignored.
- R11: A status write with bit 0 set during a copy returns the engine to idle. It does not write back the addresses and does not raise the interrupt.
- R12: During a copy, the source port holds its request high. The destination request is high only while the source is ready. A byte moves in each cycle where both ports are ready, and the copy stalls otherwise.
- R13: After completion, each destination byte in the copied range equals the source byte at the same offset. The byte just past the range is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| dram_req | output | 1 | DRAM byte access request |
| dram_we | output | 1 | DRAM access is a write |
| dram_addr | output | DRAM_AW | DRAM byte address |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte, valid while ready |
| dram_ready | input | 1 | DRAM accepts the access this cycle |
| cart_req | output | 1 | Cartridge byte access request |
| cart_we | output | 1 | Cartridge access is a write |
| cart_addr | output | 32 | Cartridge byte address |
| cart_wdata | output | 8 | Cartridge write byte |
| cart_rdata | input | 8 | Cartridge read byte, valid while ready |
| cart_ready | input | 1 | Cartridge accepts the access this cycle |
| irq | output | 1 | Level completion interrupt |

## Verification
The hardest situations to reach are register traffic that lands while a copy is in flight. These are a stray address or length write that must be dropped, an abort that must suppress the writeback, and status polls that must keep showing busy.

The bench reaches them by running long copies with the maximum length field while both ready inputs stall at random. Those copies last hundreds of cycles, and the bench issues writes and polls inside that window. A behavioural model counts the bytes remaining from the ready pattern it drives itself, and it predicts the exact completion cycle even when the memories stall.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic {
    DIR_TO_CART = 1'b0,
    DIR_TO_DRAM = 1'b1
  } cdma_dir_e;

  localparam logic [4:0] OFS_DRAM    = 5'h00;
  localparam logic [4:0] OFS_CART    = 5'h04;
  localparam logic [4:0] OFS_LEN_TC  = 5'h08;
  localparam logic [4:0] OFS_LEN_TD  = 5'h0C;
  localparam logic [4:0] OFS_STATUS  = 5'h10;

  localparam int STAT_DMA_BUSY = 0;
  localparam int STAT_IO_BUSY  = 1;
  localparam int STAT_IRQ      = 3;

  // byte count after removing the DRAM misalignment, floored at zero
  function automatic logic [31:0] shrink_len(input logic [31:0] nbytes,
                                             input logic [2:0]  skew);
    if (nbytes > 32'(skew)) return nbytes - 32'(skew);
    return 32'd0;
  endfunction
endpackage

// File: rtl/cdma_launch.sv
module cdma_launch #(
  parameter int DRAM_AW = 23,
  parameter int LEN_W   = 24,
  localparam int CNT_W  = LEN_W + 1
) (
  input  logic [DRAM_AW-1:0] dram_reg,
  input  logic [31:0]        cart_reg,
  input  logic [LEN_W-1:0]   len_field,
  output logic [31:0]        dram_base,
  output logic [31:0]        cart_base,
  output logic [CNT_W-1:0]   byte_cnt
);
  import cdma_pkg::*;

  logic [31:0] requested;
  logic [31:0] adjusted;

  always_comb begin
    dram_base = {{(32-DRAM_AW){1'b0}}, dram_reg[DRAM_AW-1:1], 1'b0};
    cart_base = {cart_reg[31:1], 1'b0};
    requested = 32'(len_field) + 32'd1;
    adjusted  = shrink_len(requested, dram_base[2:0]);
    byte_cnt  = adjusted[CNT_W-1:0];
  end
endmodule

// File: rtl/cdma_mover.sv
module cdma_mover #(
  parameter int DRAM_AW = 23,
  parameter int CNT_W   = 25
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  cdma_pkg::cdma_dir_e start_dir,
  input  logic [31:0]         start_dram,
  input  logic [31:0]         start_cart,
  input  logic [CNT_W-1:0]    start_cnt,
  input  logic                abort,
  output logic                busy,
  output logic                done,
  output logic [31:0]         lat_dram,
  output logic [31:0]         lat_cart,
  output logic [CNT_W-1:0]    lat_cnt,
  output logic                dram_req,
  output logic                dram_we,
  output logic [DRAM_AW-1:0]  dram_addr,
  output logic [7:0]          dram_wdata,
  input  logic [7:0]          dram_rdata,
  input  logic                dram_ready,
  output logic                cart_req,
  output logic                cart_we,
  output logic [31:0]         cart_addr,
  output logic [7:0]          cart_wdata,
  input  logic [7:0]          cart_rdata,
  input  logic                cart_ready
);
  import cdma_pkg::*;

  logic             busy_q;
  cdma_dir_e        dir_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] ofs_q;
  logic [31:0]      dram_b_q;
  logic [31:0]      cart_b_q;
  logic [CNT_W-1:0] cnt_q;

  logic active, src_ready, dst_ready, step, finish;
  logic [31:0] dram_full;

  always_comb begin
    active    = busy_q && (rem_q != '0);
    src_ready = (dir_q == DIR_TO_CART) ? dram_ready : cart_ready;
    dst_ready = (dir_q == DIR_TO_CART) ? cart_ready : dram_ready;
    step      = active && src_ready && dst_ready;
    finish    = busy_q && ((rem_q == '0) || ((rem_q == CNT_W'(1)) && step));
    done      = finish && !abort;
    dram_full = dram_b_q + 32'(ofs_q);
  end

  always_comb begin
    dram_we    = (dir_q == DIR_TO_DRAM);
    cart_we    = (dir_q == DIR_TO_CART);
    dram_req   = (dir_q == DIR_TO_CART) ? active : (active && cart_ready);
    cart_req   = (dir_q == DIR_TO_DRAM) ? active : (active && dram_ready);
    dram_addr  = dram_full[DRAM_AW-1:0];
    cart_addr  = cart_b_q + 32'(ofs_q);
    dram_wdata = cart_rdata;
    cart_wdata = dram_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_q    <= DIR_TO_CART;
      rem_q    <= '0;
      ofs_q    <= '0;
      dram_b_q <= '0;
      cart_b_q <= '0;
      cnt_q    <= '0;
    end else if (start && !busy_q) begin
      busy_q   <= 1'b1;
      dir_q    <= start_dir;
      rem_q    <= start_cnt;
      ofs_q    <= '0;
      dram_b_q <= start_dram;
      cart_b_q <= start_cart;
      cnt_q    <= start_cnt;
    end else if (busy_q) begin
      if (abort || finish) begin
        busy_q <= 1'b0;
      end else if (step) begin
        rem_q <= rem_q - CNT_W'(1);
        ofs_q <= ofs_q + CNT_W'(1);
      end
    end
  end

  assign busy     = busy_q;
  assign lat_dram = dram_b_q;
  assign lat_cart = cart_b_q;
  assign lat_cnt  = cnt_q;
endmodule

// File: rtl/cdma_irq.sv
module cdma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pending <= 1'b0;
    else if (set) pending <= 1'b1;
    else if (clr) pending <= 1'b0;
  end
endmodule

// File: rtl/cart_dma_engine.sv
module cart_dma_engine #(
  parameter int DRAM_AW = 23,
  parameter int LEN_W   = 24,
  localparam int CNT_W  = LEN_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               dram_req,
  output logic               dram_we,
  output logic [DRAM_AW-1:0] dram_addr,
  output logic [7:0]         dram_wdata,
  input  logic [7:0]         dram_rdata,
  input  logic               dram_ready,
  output logic               cart_req,
  output logic               cart_we,
  output logic [31:0]        cart_addr,
  output logic [7:0]         cart_wdata,
  input  logic [7:0]         cart_rdata,
  input  logic               cart_ready,
  output logic               irq
);
  import cdma_pkg::*;

  logic [31:0] dram_addr_q, cart_addr_q, len_tc_q, len_td_q;

  // named internal events, also used by the bound checker
  logic             mv_busy;
  logic             done_evt;
  logic             start_evt;
  logic             abort_evt;
  logic             clr_evt;
  logic             ign_evt;
  logic             irq_pend;
  cdma_dir_e        start_dir;
  logic [31:0]      base_dram, base_cart;
  logic [CNT_W-1:0] base_cnt;
  logic [31:0]      lat_dram, lat_cart;
  logic [CNT_W-1:0] lat_cnt;

  logic wr_len_tc, wr_len_td, wr_status;

  always_comb begin
    wr_len_tc = reg_we && (reg_addr == OFS_LEN_TC);
    wr_len_td = reg_we && (reg_addr == OFS_LEN_TD);
    wr_status = reg_we && (reg_addr == OFS_STATUS);
    start_evt = (wr_len_tc || wr_len_td) && !mv_busy;
    start_dir = wr_len_td ? DIR_TO_DRAM : DIR_TO_CART;
    abort_evt = wr_status && reg_wdata[0] && mv_busy;
    clr_evt   = wr_status && reg_wdata[1];
    ign_evt   = reg_we && mv_busy &&
                ((reg_addr == OFS_DRAM) || (reg_addr == OFS_CART) ||
                 (reg_addr == OFS_LEN_TC) || (reg_addr == OFS_LEN_TD));
  end

  cdma_launch #(.DRAM_AW(DRAM_AW), .LEN_W(LEN_W)) u_launch (
    .dram_reg  (dram_addr_q[DRAM_AW-1:0]),
    .cart_reg  (cart_addr_q),
    .len_field (reg_wdata[LEN_W-1:0]),
    .dram_base (base_dram),
    .cart_base (base_cart),
    .byte_cnt  (base_cnt)
  );

  cdma_mover #(.DRAM_AW(DRAM_AW), .CNT_W(CNT_W)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start_evt),
    .start_dir  (start_dir),
    .start_dram (base_dram),
    .start_cart (base_cart),
    .start_cnt  (base_cnt),
    .abort      (abort_evt),
    .busy       (mv_busy),
    .done       (done_evt),
    .lat_dram   (lat_dram),
    .lat_cart   (lat_cart),
    .lat_cnt    (lat_cnt),
    .dram_req   (dram_req),
    .dram_we    (dram_we),
    .dram_addr  (dram_addr),
    .dram_wdata (dram_wdata),
    .dram_rdata (dram_rdata),
    .dram_ready (dram_ready),
    .cart_req   (cart_req),
    .cart_we    (cart_we),
    .cart_addr  (cart_addr),
    .cart_wdata (cart_wdata),
    .cart_rdata (cart_rdata),
    .cart_ready (cart_ready)
  );

  cdma_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (done_evt),
    .clr     (clr_evt),
    .pending (irq_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_addr_q <= '0;
      cart_addr_q <= '0;
      len_tc_q    <= '0;
      len_td_q    <= '0;
    end else if (done_evt) begin
      dram_addr_q <= lat_dram + 32'(lat_cnt);
      cart_addr_q <= lat_cart + 32'(lat_cnt);
    end else if (!mv_busy && reg_we) begin
      if (reg_addr == OFS_DRAM) dram_addr_q <= reg_wdata;
      if (reg_addr == OFS_CART) cart_addr_q <= reg_wdata;
      if (wr_len_tc) len_tc_q <= 32'(base_cnt);
      if (wr_len_td) len_td_q <= 32'(base_cnt);
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_DRAM:   reg_rdata = dram_addr_q;
      OFS_CART:   reg_rdata = cart_addr_q;
      OFS_LEN_TC: reg_rdata = len_tc_q;
      OFS_LEN_TD: reg_rdata = len_td_q;
      OFS_STATUS: begin
        reg_rdata = '0;
        reg_rdata[STAT_DMA_BUSY] = mv_busy;
        reg_rdata[STAT_IO_BUSY]  = mv_busy;
        reg_rdata[STAT_IRQ]      = irq_pend;
      end
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = irq_pend;
endmodule

// File: rtl/cdma_checker.sv
module cdma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        start_evt,
  input logic        done_evt,
  input logic        abort_evt,
  input logic        clr_evt,
  input logic        ign_evt,
  input logic        irq,
  input logic        dram_req,
  input logic        cart_req,
  input logic [31:0] dram_reg
);
  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy); // R7

  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq); // R8

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_evt) |=> irq); // R8

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !done_evt) |=> !irq); // R9

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_evt && !done_evt) |=> $stable(dram_reg)); // R10

  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !busy); // R11

  AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_evt && !irq) |=> !irq); // R11

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!dram_req && !cart_req)); // R12
endmodule

bind cart_dma_engine cdma_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (mv_busy),
  .start_evt (start_evt),
  .done_evt  (done_evt),
  .abort_evt (abort_evt),
  .clr_evt   (clr_evt),
  .ign_evt   (ign_evt),
  .irq       (irq),
  .dram_req  (dram_req),
  .cart_req  (cart_req),
  .dram_reg  (dram_addr_q)
);

// File: tb/cart_dma_engine_test.sv
module cart_dma_engine_test;
  localparam int AW = 23;
  localparam int LW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = 5'h10;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dram_req, dram_we, cart_req, cart_we, irq;
  logic [AW-1:0] dram_addr;
  logic [31:0] cart_addr;
  logic [7:0] dram_wdata, cart_wdata, dram_rdata, cart_rdata;
  logic dram_rdy = 1'b1, cart_rdy = 1'b1;
  logic stall = 1'b0;

  logic [7:0] dmem [0:1023];
  logic [7:0] cmem [0:1023];
  logic [7:0] snap_src [0:1023];
  logic [7:0] snap_dst [0:1023];

  int checks = 0, errors = 0;

  // behavioural model state
  bit m_busy = 0, m_irq = 0;
  int m_rem = 0;
  int next_len = 0;

  always #10 clk = ~clk;

  cart_dma_engine #(.DRAM_AW(AW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .dram_ready(dram_rdy),
    .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
    .cart_wdata(cart_wdata), .cart_rdata(cart_rdata), .cart_ready(cart_rdy),
    .irq(irq)
  );

  assign dram_rdata = dmem[dram_addr[9:0]];
  assign cart_rdata = cmem[cart_addr[9:0]];

  always @(posedge clk) begin
    if (dram_req && dram_we && dram_rdy) dmem[dram_addr[9:0]] <= dram_wdata;
    if (cart_req && cart_we && cart_rdy) cmem[cart_addr[9:0]] <= cart_wdata;
  end

  always @(negedge clk) begin
    if (stall) begin
      dram_rdy <= ($urandom % 4) != 0;
      cart_rdy <= ($urandom % 3) != 0;
    end else begin
      dram_rdy <= 1'b1;
      cart_rdy <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // model update at each edge, then per-cycle comparison
  always @(posedge clk) begin
    bit fin, xfer, ab, clr;
    fin = 0;
    if (rst_n) begin
      ab  = reg_we && reg_addr == 5'h10 && reg_wdata[0];
      clr = reg_we && reg_addr == 5'h10 && reg_wdata[1];
      if (m_busy) begin
        xfer = (m_rem != 0) && dram_rdy && cart_rdy;
        if (ab) m_busy = 0;
        else if (m_rem == 0 || (m_rem == 1 && xfer)) begin
          m_busy = 0; m_irq = 1; fin = 1;
        end else if (xfer) m_rem--;
      end else if (reg_we && (reg_addr == 5'h08 || reg_addr == 5'h0C)) begin
        m_busy = 1; m_rem = next_len;
      end
      if (clr && !fin) m_irq = 0;
      #5;
      check(irq == m_irq, "R8/R9 irq level", irq, m_irq);
      if (uut.dram_we) begin
        check(cart_req == (m_busy && m_rem != 0), "R12 source request", cart_req, m_busy && m_rem != 0);
        check(dram_req == (m_busy && m_rem != 0 && cart_rdy), "R12 dest request", dram_req, m_busy && m_rem != 0 && cart_rdy);
      end else begin
        check(dram_req == (m_busy && m_rem != 0), "R12 source request", dram_req, m_busy && m_rem != 0);
        check(cart_req == (m_busy && m_rem != 0 && dram_rdy), "R12 dest request", cart_req, m_busy && m_rem != 0 && dram_rdy);
      end
      if (!reg_we && reg_addr == 5'h10)
        check(reg_rdata == {28'd0, m_irq, 1'b0, m_busy, m_busy}, "R7 status poll",
              reg_rdata, {28'd0, m_irq, 1'b0, m_busy, m_busy});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 5'h10; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
    reg_addr = 5'h10;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
  endtask

  // full transfer with model-derived expectations
  task automatic run_xfer(input bit to_dram, input logic [31:0] da, input logic [31:0] ca,
                          input logic [31:0] lenval, input bit stl, input bit poke);
    logic [31:0] db, cb, v;
    int n, skew, len, bad;
    db = {9'd0, da[22:1], 1'b0};
    cb = {ca[31:1], 1'b0};
    n = int'(lenval[LW-1:0]) + 1;
    skew = int'(db[2:0]);
    len = (n > skew) ? n - skew : 0;
    wr(5'h00, da);
    wr(5'h04, ca);
    for (int i = 0; i < 1024; i++) begin
      snap_src[i] = to_dram ? cmem[i] : dmem[i];
      snap_dst[i] = to_dram ? dmem[i] : cmem[i];
    end
    next_len = len;
    stall = stl;
    wr(to_dram ? 5'h0C : 5'h08, lenval);
    if (poke && m_busy) begin
      wr(5'h00, 32'h55);                  // R10 ignored while busy
      wr(to_dram ? 5'h08 : 5'h0C, 32'h3); // R10 ignored while busy
    end
    wait_idle();
    stall = 0;
    rd(to_dram ? 5'h0C : 5'h08, v);
    check(v == 32'(len), "R6 R3 R5 length readback", v, len);
    rd(5'h00, v);
    check(v == db + 32'(len), "R8 R4 R10 dram writeback", v, db + 32'(len));
    rd(5'h04, v);
    check(v == cb + 32'(len), "R8 R4 cart writeback", v, cb + 32'(len));
    bad = 0;
    for (int i = 0; i < len; i++) begin
      if (to_dram) begin if (dmem[(db[9:0] + i) % 1024] != snap_src[(cb[9:0] + i) % 1024]) bad++; end
      else begin if (cmem[(cb[9:0] + i) % 1024] != snap_src[(db[9:0] + i) % 1024]) bad++; end
    end
    if (to_dram) begin if (dmem[(db[9:0] + len) % 1024] != snap_dst[(db[9:0] + len) % 1024]) bad++; end
    else begin if (cmem[(cb[9:0] + len) % 1024] != snap_dst[(cb[9:0] + len) % 1024]) bad++; end
    check(bad == 0, "R13 R2 copied data", bad, 0);
    check(irq == 1'b1, "R8 irq after completion", irq, 1);
    wr(5'h10, 32'h2);
    check(irq == 1'b0, "R9 irq cleared", irq, 0);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) begin
      dmem[i] = 8'(i * 7 + 3);
      cmem[i] = 8'(i * 13 + 5);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(5'h10, v); check(v == 0, "R7 reset status", v, 0);
    rd(5'h00, v); check(v == 0, "R1 reset dram reg", v, 0);
    check(irq == 0, "R8 reset irq", irq, 0);

    wr(5'h00, 32'h1234_5679);
    rd(5'h00, v); check(v == 32'h1234_5679, "R1 dram readback", v, 32'h1234_5679);
    wr(5'h04, 32'h9ABC_DEF1);
    rd(5'h04, v); check(v == 32'h9ABC_DEF1, "R1 cart readback", v, 32'h9ABC_DEF1);

    run_xfer(1, 32'hFF80_0200, 32'h0000_0101, 32'h0000_000F, 0, 0);
    run_xfer(0, 32'h0000_0180, 32'h0000_0301, 32'hFFFF_FE1F, 0, 0);
    for (int k = 1; k <= 7; k++)
      run_xfer(0, 32'h0000_0080 + 32'(k), 32'h0000_0240, 32'd20, 0, 0);
    run_xfer(1, 32'h0000_0007, 32'h0000_0050, 32'd3, 0, 0);   // R5 zero bytes
    run_xfer(1, 32'h0000_0100, 32'h0000_0020, 32'hFFFF_FFFF, 1, 1);
    run_xfer(0, 32'h0000_0010, 32'h0000_0200, 32'hFFFF_FFFF, 1, 1);

    // R11 abort
    wr(5'h00, 32'h0000_0040);
    wr(5'h04, 32'h0000_0300);
    next_len = 201;
    wr(5'h0C, 32'd200);
    repeat (10) @(negedge clk);
    wr(5'h10, 32'h1);
    rd(5'h10, v); check(v == 0, "R11 idle after abort", v, 0);
    rd(5'h00, v); check(v == 32'h40, "R11 dram reg kept", v, 32'h40);
    rd(5'h04, v); check(v == 32'h300, "R11 cart reg kept", v, 32'h300);
    repeat (5) @(negedge clk);
    check(irq == 0, "R11 no irq after abort", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule